// File: doc/BRIEF.md
# Predicate Mask Bit-Manipulation Stage

This block is one registered pipeline stage that turns a 64-bit source word into a predicate-style bitmask. It reads a 32-bit instruction word, picks a 5-bit operation selector, a merge flag and a mask register index out of it, and combines the source with a variant of itself: the source or its inverse, together with a negated, decremented, incremented or inverted-incremented copy. The combiner is OR, AND or XOR. Typical uses are isolating or clearing the lowest set bit, or building a run of ones up to the first set bit.

A mask operand can limit the work to a subset of bit lanes. When the instruction's mask register index is zero, no lanes are excluded. Otherwise, lanes where the mask is 0 are forced to zero in the result. With the merge flag set, those lanes take the original source bits instead. A selector whose combiner code is reserved produces no result and raises a one-cycle illegal flag instead.

Operations enter on a valid/ready input and leave on a valid/ready output after one clock edge. The input is ready whenever the output slot is empty or is being drained in the same cycle. While a result sits unconsumed, `in_ready` is low and the result stays stable. The illegal flag is a plain status pulse and ignores back-pressure.

Top module: `bmu_mask_stage`

## Requirements
- R1: Fields are taken from `insn` as follows, counting bit 0 as the LSB: selector `sel` = insn[10:6], merge flag = insn[5], mask register index = insn[15:11]. All other bits have no effect.
- R2: The mask is all ones when the mask register index is zero, and equals `mask_val` otherwise. The working value `w` is `src_val & mask`.
- R3: With sel[0]=1 the first term is `w`. With sel[0]=0 it is `~w`.
- R4: The code sel[2:1] picks the second term: 0 gives `~w+1`, 1 gives `w-1`, 2 gives `w+1`, 3 gives `~(w+1)`.
- R5: Both terms are ANDed with the mask. The code sel[4:3] then combines them: 0 gives OR, 1 gives AND, 2 gives XOR.
- R6: The combined value is ANDed with the mask. When the merge flag is 1, lanes where the mask is 0 take the corresponding `src_val` bits.
- R7: All arithmetic wraps modulo 2^64. There is no carry or overflow output.
- R8: Code sel[4:3]=3 is reserved. In the cycle after such an operation is accepted, `illegal` is 1, `out_valid` is 0 and `result` is 0.
- R9: A legal operation accepted at a clock edge is presented with `out_valid`=1 right after that edge. A drained slot with no new acceptance shows `out_valid`=0 after the edge.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `result` and `out_valid` hold.
- R11: During and right after reset, `out_valid`=0, `illegal`=0, `result`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation this cycle |
| insn | input | 32 | Instruction word holding selector, merge flag and mask index |
| src_val | input | 64 | Source operand |
| mask_val | input | 64 | Mask register value |
| out_valid | output | 1 | Result held in the output slot |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 64 | Computed mask word |
| illegal | output | 1 | One-cycle pulse for an accepted reserved selector |

## Verification
The hardest case to reach from the ports is a stalled result being drained at the same edge that a new operation is accepted. Reaching it needs a run of stall cycles with a second operation already waiting on the input, followed by the release of `out_ready`. The stimulus sets this up on purpose. It holds `out_ready` low with `in_valid` up and checks that the first result holds. It then releases the consumer and checks that the next operation's result appears right after the same edge. The merge path is also exercised with a mask that is neither all ones nor zero, so that kept, cleared and restored lanes all appear in one word.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int INSN_W    = 32;
  localparam int IDX_W     = 5;
  localparam int SEL_W     = 5;
  localparam int SEL_LSB   = 6;
  localparam int MERGE_POS = 5;
  localparam int MIDX_LSB  = 11;
  localparam int COMB_LSB  = SEL_LSB + 3;

  typedef enum logic [1:0] {
    CMB_OR   = 2'd0,
    CMB_AND  = 2'd1,
    CMB_XOR  = 2'd2,
    CMB_RSVD = 2'd3
  } combine_e;

  typedef enum logic [1:0] {
    ADJ_NEG  = 2'd0,
    ADJ_DEC  = 2'd1,
    ADJ_INC  = 2'd2,
    ADJ_NINC = 2'd3
  } adjust_e;

  typedef struct packed {
    combine_e comb;
    adjust_e  adj;
    logic     keep_true;
    logic     merge;
    logic     mask_en;
    logic     bad_sel;
  } op_ctl_t;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output op_ctl_t           ctl
);

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] midx;
  logic             unused_bits;

  assign sel  = insn[SEL_LSB +: SEL_W];
  assign midx = insn[MIDX_LSB +: IDX_W];
  assign unused_bits = ^{insn[INSN_W-1:MIDX_LSB+IDX_W], insn[MERGE_POS-1:0]};

  always_comb begin
    ctl.comb      = combine_e'(sel[4:3]);
    ctl.adj       = adjust_e'(sel[2:1]);
    ctl.keep_true = sel[0];
    ctl.merge     = insn[MERGE_POS];
    ctl.mask_en   = |midx;
    ctl.bad_sel   = (sel[4:3] == CMB_RSVD);
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  op_ctl_t           ctl,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] mask_val,
  output logic [DATA_W-1:0] res
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] mask, w, w_inc, w_dec;
  logic [DATA_W-1:0] t1, t2, t1m, t2m, comb, kept;

  assign mask  = ctl.mask_en ? mask_val : '1;
  assign w     = src_val & mask;
  assign w_inc = w + ONE;
  assign w_dec = w - ONE;
  assign t1    = ctl.keep_true ? w : ~w;

  always_comb begin
    case (ctl.adj)
      ADJ_NEG:  t2 = ~w + ONE;
      ADJ_DEC:  t2 = w_dec;
      ADJ_INC:  t2 = w_inc;
      default:  t2 = ~w_inc;
    endcase
  end

  assign t1m = t1 & mask;
  assign t2m = t2 & mask;

  always_comb begin
    case (ctl.comb)
      CMB_OR:  comb = t1m | t2m;
      CMB_AND: comb = t1m & t2m;
      CMB_XOR: comb = t1m ^ t2m;
      default: comb = '0;
    endcase
  end

  // per-lane restore: masked-off lanes either zero or source
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign kept[i] = mask[i] ? comb[i] : (ctl.merge & src_val[i]);
  end

  assign res = kept;

endmodule

// File: rtl/bmu_out_slot.sv
module bmu_out_slot #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              bad,
  input  logic              drain,
  input  logic [DATA_W-1:0] d,
  output logic              full,
  output logic [DATA_W-1:0] q,
  output logic              bad_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      q         <= '0;
      bad_pulse <= 1'b0;
    end else begin
      bad_pulse <= take & bad;
      if (take) begin
        full <= ~bad;
        q    <= bad ? '0 : d;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bmu_mask_stage.sv
module bmu_mask_stage
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] mask_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  op_ctl_t           ctl;
  logic [DATA_W-1:0] res_d;
  logic              take;

  bmu_decode u_dec (
    .insn (insn),
    .ctl  (ctl)
  );

  bmu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl      (ctl),
    .src_val  (src_val),
    .mask_val (mask_val),
    .res      (res_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  bmu_out_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .bad       (ctl.bad_sel),
    .drain     (out_ready),
    .d         (res_d),
    .full      (out_valid),
    .q         (result),
    .bad_pulse (illegal)
  );

endmodule

// File: rtl/bmu_mask_stage_chk.sv
module bmu_mask_stage_chk
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INSN_W-1:0] insn,
  input logic [DATA_W-1:0] mask_val,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  logic       acc, rsvd, masked, merge;
  assign acc    = in_valid & in_ready;
  assign rsvd   = (insn[COMB_LSB +: 2] == 2'b11);
  assign masked = |insn[MIDX_LSB +: IDX_W];
  assign merge  = insn[MERGE_POS];

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result))); // R10
  AST_NO_TAKE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_LEGAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rsvd) |=> (out_valid && !illegal)); // R9
  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid); // R9
  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsvd) |=> (illegal && !out_valid && result == '0)); // R8
  AST_MASK_CONFINES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rsvd && masked && !merge) |=> ((result & ~$past(mask_val)) == '0)); // R6

endmodule

bind bmu_mask_stage bmu_mask_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .insn      (insn),
  .mask_val  (mask_val),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/sim_bmu_mask_stage.sv
`timescale 1ns/1ps
module sim_bmu_mask_stage;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [63:0] src_val = '0;
  logic [63:0] mask_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        illegal;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bmu_mask_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .src_val(src_val), .mask_val(mask_val),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .illegal(illegal)
  );

  localparam int NV = 12;
  localparam logic [4:0]  V_SEL [NV] = '{5'b00011, 5'b01011, 5'b10011, 5'b01001,
                                         5'b01100, 5'b00111, 5'b10011, 5'b10101,
                                         5'b10011, 5'b10011, 5'b00011, 5'b00000};
  localparam logic        V_L   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [4:0]  V_IDX [NV] = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,
                                         5'd0, 5'd0, 5'd7, 5'd7, 5'd0, 5'd0};
  localparam logic [63:0] V_SRC [NV] = '{64'hF0, 64'hF0, 64'hF0, 64'hF0, 64'h0F, 64'h0F,
                                         64'h0, '1, 64'h1234_5678_9ABC_F0F0,
                                         64'h1234_5678_9ABC_F0F0, 64'hF0, 64'hF0};
  localparam logic [63:0] V_MSK [NV] = '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
                                         64'h0, 64'h0, 64'hFF00, 64'hFF00, 64'h0, 64'h0};
  localparam logic [63:0] V_EXP [NV] = '{64'hFF, 64'hE0, 64'h1F, 64'h10, 64'h10,
                                         64'hFFFF_FFFF_FFFF_FFEF, '1, '1, 64'h1F00,
                                         64'h1234_5678_9ABC_1FF0, 64'hFF,
                                         64'hFFFF_FFFF_FFFF_FF1F};
  localparam string       V_TAG [NV] = '{"R2 R3 R4 R5", "R5 AND", "R5 XOR", "R4 negate",
                                         "R3 R4 inc", "R4 inv-inc", "R7 dec wrap",
                                         "R7 inc wrap", "R2 R6 masked", "R1 R6 merge",
                                         "R6 merge no-op", "R3 R4 inverted"};

  function automatic logic [31:0] mk(input logic [4:0] idx, input logic [4:0] sel,
                                     input logic l);
    mk = {6'd4, 5'd3, 5'd5, idx, sel, l, 5'd9};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] w, input logic [63:0] s, input logic [63:0] m);
    @(negedge clk);
    insn = w; src_val = s; mask_val = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 illegal", {63'd0, illegal}, 64'd0);
    check("R11 result", result, 64'd0);
    check("R11 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 post-reset out_valid", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      present(mk(V_IDX[i], V_SEL[i], V_L[i]), V_SRC[i], V_MSK[i]);
      check({V_TAG[i], " R9 valid"}, {63'd0, out_valid}, 64'd1);
      check(V_TAG[i], result, V_EXP[i]);
    end
    @(negedge clk);
    check("R9 drained", {63'd0, out_valid}, 64'd0);

    // R1: bits outside the fields have no effect
    present({6'h3F, 5'h1F, 5'h1F, 5'd0, 5'b10011, 1'b0, 5'h1F}, 64'hF0, 64'h0);
    check("R1 other bits", result, 64'h1F);

    // R8: reserved combiner
    present(mk(5'd0, 5'b11011, 1'b0), 64'hF0, 64'h0);
    check("R8 illegal", {63'd0, illegal}, 64'd1);
    check("R8 no valid", {63'd0, out_valid}, 64'd0);
    check("R8 zero result", result, 64'd0);
    @(negedge clk);
    check("R8 pulse ends", {63'd0, illegal}, 64'd0);

    // R10: back-pressure, then drain and accept on the same edge
    out_ready = 1'b0;
    present(mk(5'd0, 5'b00011, 1'b0), 64'hF0, 64'h0);
    check("R10 first result", result, 64'hFF);
    insn = mk(5'd0, 5'b10011, 1'b0); src_val = 64'hF0; in_valid = 1'b1;
    @(negedge clk);
    check("R10 in_ready low", {63'd0, in_ready}, 64'd0);
    check("R10 held result", result, 64'hFF);
    @(negedge clk);
    check("R10 still held", result, 64'hFF);
    check("R10 still valid", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 R10 next result", result, 64'h1F);
    check("R9 R10 next valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R9 empty", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule